// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block is a clocked monostable pulse generator. Two trigger inputs start a pulse: one responds to a falling edge, the other to a rising edge. Each edge counts only while the other input sits at its enabling level, so either input can act as a gate for the other. The pulse length is a 16-bit count of clock cycles, captured when each valid trigger is accepted. A down-counter then times the pulse, so the cost of a longer pulse is only the counter width.

A trigger that arrives while a pulse is running reloads the counter. The pulse therefore ends one full length after the last accepted trigger. An active-low clear input forces the output low, blocks all triggers while it is held, and never starts a pulse when it is released. After a release, a short recovery window drops triggers before normal operation resumes.

All three control inputs are asynchronous. Each passes through a two-flop synchroniser before edge detection. The block drives the pulse and its exact complement.

Top module: `retrig_oneshot`

## Requirements
- R1: A high-to-low edge on `trigFallN` while `trigRise` is high and `clearN` is high starts a pulse. The same edge while `trigRise` is low starts nothing.
- R2: A low-to-high edge on `trigRise` while `trigFallN` is low and `clearN` is high starts a pulse. The same edge while `trigFallN` is high starts nothing.
- R3: While `clearN` is low, `pulseOut` is low, `pulseOutN` is high, and every trigger edge is ignored.
- R4: Raising `clearN` never starts a pulse, even when the trigger inputs already hold a triggering combination.
- R5: `pulseOut` goes high at the third rising clock edge after the trigger edge is applied, whatever pulse length is programmed.
- R6: A pulse stays high for exactly `pulseLen` cycles, and a value of 0 gives 1 cycle. The value is captured at the accepting edge, so later changes to `pulseLen` do not alter a running pulse.
- R7: A valid trigger during a pulse reloads the count. The output stays high until `pulseLen` cycles after the output latency of that latest trigger.
- R8: Pulling `clearN` low during a pulse drives `pulseOut` low at the third rising clock edge after the clear is applied, which cuts the pulse short.
- R9: After `clearN` rises, a trigger edge applied 3 or fewer cycles later is dropped. One applied 4 or more cycles later is accepted.
- R10: `pulseOutN` is always the inverse of `pulseOut`.
- R11: Synchronous reset `rst` makes `pulseOut` low and leaves no recovery window, so a trigger applied as reset is released is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigFallN | input | 1 | Falling-edge trigger, asynchronous |
| trigRise | input | 1 | Rising-edge trigger, asynchronous |
| clearN | input | 1 | Active-low clear, asynchronous |
| pulseLen | input | 16 | Pulse length in clock cycles (0 acts as 1) |
| pulseOut | output | 1 | Pulse output |
| pulseOutN | output | 1 | Complement of pulse output |

## Verification
A trigger or clear applied to the pins passes through two synchroniser flops, and the counter then updates on the third rising edge. The bench drives on falling edges and expects a response at the third following falling edge. It then counts the high samples and compares that count with the programmed length, or for a retrigger with the retrigger latency plus the length minus one. The recovery window is probed with triggers applied exactly 3 and 4 cycles after clear release, which places each one on one side of the point where the window expires.

// File: rtl/retrig_oneshot_pkg.sv
`timescale 1ns/1ps
package retrig_oneshot_pkg;
  // Strobes from control to the pulse counter.
  typedef struct packed {
    logic load;   // capture length and start or extend a pulse
    logic clear;  // empty the counter
  } dpStrobe_t;

  localparam int SYNC_STAGES = 2;
  localparam int IN_COUNT    = 3;
  // Bit order of the synchronised input vector.
  localparam int IDX_FALL  = 0;
  localparam int IDX_RISE  = 1;
  localparam int IDX_CLEAR = 2;
endpackage

// File: rtl/retrig_oneshot_sync.sv
`timescale 1ns/1ps
module retrig_oneshot_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RST_VAL;
        else     stage[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RST_VAL;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
  assign prevOut = stage[STAGES];
endmodule

// File: rtl/retrig_oneshot_ctrl.sv
`timescale 1ns/1ps
module retrig_oneshot_ctrl
  import retrig_oneshot_pkg::*;
#(
  parameter int REC_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IN_COUNT-1:0] syncIn,
  input  logic [IN_COUNT-1:0] prevIn,
  output dpStrobe_t           strobe
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYCLES);

  logic fallS, riseS, clrS;
  logic fallP, riseP, clrP;
  logic fallEdge, riseEdge, armed;
  logic [REC_W-1:0] recCnt;

  assign fallS = syncIn[IDX_FALL];
  assign riseS = syncIn[IDX_RISE];
  assign clrS  = syncIn[IDX_CLEAR];
  assign fallP = prevIn[IDX_FALL];
  assign riseP = prevIn[IDX_RISE];
  assign clrP  = prevIn[IDX_CLEAR];

  assign fallEdge = fallP & ~fallS & riseS;
  assign riseEdge = ~riseP & riseS & ~fallS;

  // Recovery window: held full while clear is low, drains after release.
  always_ff @(posedge clk) begin
    if (rst)                 recCnt <= '0;
    else if (!clrS)          recCnt <= REC_LOAD;
    else if (recCnt != '0)   recCnt <= recCnt - 1'b1;
  end

  assign armed        = clrS && (recCnt == '0);
  assign strobe.load  = armed && (fallEdge || riseEdge);
  assign strobe.clear = ~clrS;

  AST_RELEASE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clrS && !clrP) |-> !strobe.load); // R4
  AST_RECOVER_TICKS: assert property (@(posedge clk) disable iff (rst)
    (clrS && recCnt != '0) |=> (recCnt == $past(recCnt) - 1'b1)); // R9
endmodule

// File: rtl/retrig_oneshot_dp.sv
`timescale 1ns/1ps
module retrig_oneshot_dp
  import retrig_oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             pulseActive
);
  logic [LEN_W-1:0] count;
  logic [LEN_W-1:0] lenEff;

  assign lenEff = (pulseLen == '0) ? LEN_W'(1) : pulseLen;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (strobe.clear)  count <= '0;
    else if (strobe.load)   count <= lenEff;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign pulseActive = (count != '0);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> !pulseActive); // R3
  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> pulseActive); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (count > LEN_W'(1) && !strobe.load && !strobe.clear)
      |=> (count == $past(count) - 1'b1)); // R6
endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
  import retrig_oneshot_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int REC_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigFallN,
  input  logic             trigRise,
  input  logic             clearN,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             pulseOut,
  output logic             pulseOutN
);
  // Reset values match idle levels so reset creates no edge or clear.
  localparam logic [IN_COUNT-1:0] SYNC_RST = 3'b101;

  logic [IN_COUNT-1:0] rawIn, syncIn, prevIn;
  dpStrobe_t strobe;
  logic pulseActive;

  assign rawIn = {clearN, trigRise, trigFallN};

  retrig_oneshot_sync #(
    .WIDTH(IN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst(rst), .asyncIn(rawIn), .syncOut(syncIn), .prevOut(prevIn)
  );

  retrig_oneshot_ctrl #(.REC_CYCLES(REC_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .syncIn(syncIn), .prevIn(prevIn), .strobe(strobe)
  );

  retrig_oneshot_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .pulseLen(pulseLen),
    .pulseActive(pulseActive)
  );

  assign pulseOut  = pulseActive;
  assign pulseOutN = ~pulseActive;
endmodule

// File: tb/retrig_oneshot_bench.sv
`timescale 1ns/1ps
module retrig_oneshot_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigFallN = 1'b0;
  logic trigRise = 1'b0;
  logic clearN = 1'b1;
  logic [15:0] pulseLen = 16'd4;
  logic pulseOut, pulseOutN;

  int nChecks = 0;
  int nFails = 0;
  int compErr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  retrig_oneshot u_retrig_oneshot (
    .clk(clk), .rst(rst), .trigFallN(trigFallN), .trigRise(trigRise),
    .clearN(clearN), .pulseLen(pulseLen), .pulseOut(pulseOut),
    .pulseOutN(pulseOutN)
  );

  typedef struct packed {
    logic        useRise;
    logic [15:0] len;
    int          expW;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{useRise: 1'b0, len: 16'd5,   expW: 5},
    '{useRise: 1'b1, len: 16'd1,   expW: 1},
    '{useRise: 1'b0, len: 16'd0,   expW: 1},
    '{useRise: 1'b1, len: 16'd17,  expW: 17},
    '{useRise: 1'b0, len: 16'd300, expW: 300},
    '{useRise: 1'b1, len: 16'd2,   expW: 2}
  };

  always @(negedge clk) if (!rst && pulseOutN !== ~pulseOut) compErr++;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lat, output int width);
    lat = 0;
    do begin step(); lat++; end while (!pulseOut && lat < 40);
    width = 0;
    while (pulseOut && width < 70000) begin width++; step(); end
  endtask

  task automatic toIdle();
    trigFallN = 1'b1; trigRise = 1'b0; step(4);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    int lat, w, hi;
    step(3);
    // R11: reset state
    chk("R11 reset pulseOut", pulseOut, 0);
    chk("R10 reset pulseOutN", pulseOutN, 1);
    // R11: trigger applied as reset drops is accepted (no recovery window)
    rst = 1'b0; trigRise = 1'b1;
    measure(lat, w);
    chk("R11 latency after reset", lat, 3);
    chk("R11 width after reset", w, 4);
    toIdle();

    // Table: R1, R2, R5, R6
    foreach (VECS[i]) begin
      pulseLen = VECS[i].len;
      if (VECS[i].useRise) begin
        trigFallN = 1'b0; step(4);   // fall edge with rise-input low: gated
        chk("R1 gated fall edge", pulseOut, 0);
        trigRise = 1'b1;
      end else begin
        trigRise = 1'b1; step(4);    // rise edge with fall-input high: gated
        chk("R2 gated rise edge", pulseOut, 0);
        trigFallN = 1'b0;
      end
      measure(lat, w);
      chk(VECS[i].useRise ? "R2 latency R5" : "R1 latency R5", lat, 3);
      chk("R6 width", w, VECS[i].expW);
      toIdle();
    end

    // R7: retrigger extends
    pulseLen = 16'd10;
    trigFallN = 1'b0; step(4);
    trigRise = 1'b1; step(2);
    trigRise = 1'b0; step(3);
    trigRise = 1'b1;
    measure(lat, w);
    chk("R7 still high at retrigger", lat, 1);
    chk("R7 extended width", w, 12);
    toIdle();

    // R6: length captured at load, later change ignored
    pulseLen = 16'd8;
    trigFallN = 1'b0; step(4);
    trigRise = 1'b1; step(3);
    chk("R6 high before change", pulseOut, 1);
    pulseLen = 16'd2;
    hi = 0;
    while (pulseOut && hi < 100) begin hi++; step(); end
    chk("R6 captured width", hi, 8);
    toIdle();

    // R8: clear cuts a pulse short
    pulseLen = 16'd20;
    trigFallN = 1'b0; step(4);
    trigRise = 1'b1; step(6);
    clearN = 1'b0;
    hi = 0;
    step();
    while (pulseOut && hi < 100) begin hi++; step(); end
    chk("R8 highs after clear applied", hi, 2);

    // R3: triggers ignored while clear low
    trigRise = 1'b0; step(3);
    trigRise = 1'b1; step(6);
    chk("R3 trigger during clear", pulseOut, 0);
    chk("R3 complement during clear", pulseOutN, 1);

    // R4: release with triggering combination held
    clearN = 1'b1;
    hi = 0;
    for (int k = 0; k < 12; k++) begin step(); if (pulseOut) hi++; end
    chk("R4 no pulse on release", hi, 0);

    // R9: trigger 3 cycles after release dropped
    pulseLen = 16'd6;
    clearN = 1'b0; trigRise = 1'b0; step(4);
    clearN = 1'b1; step(3);
    trigRise = 1'b1;
    measure(lat, w);
    chk("R9 trigger at 3 cycles dropped", w, 0);

    // R9: trigger 4 cycles after release accepted
    clearN = 1'b0; trigRise = 1'b0; step(4);
    clearN = 1'b1; step(4);
    trigRise = 1'b1;
    measure(lat, w);
    chk("R9 trigger at 4 cycles latency", lat, 3);
    chk("R9 trigger at 4 cycles width", w, 6);
    toIdle();

    chk("R10 complement mismatches", compErr, 0);
    finishRun();
  end
endmodule